// File: doc/BRIEF.md
# Trap Prioritizer and Trap Register Capture

This block sits beside the control path of a 32-bit RISC-V-style core. Each cycle it looks at every synchronous fault flag and every interrupt line that is already masked by its enable bit. It picks the single request with the highest priority and reports it on a combinational take strobe, together with the full cause word. On the same clock edge it writes the three machine trap registers: the cause, the exception PC and the trap value.

Synchronous faults always beat interrupts. Among the interrupts, the sixteen fast channels come first, in channel order. The machine external, software and timer interrupts follow, in that order.

The trap value depends on the kind of trap:
- a fetch fault gives the fetch address with bit 0 cleared;
- a load or store fault gives the data address;
- an illegal instruction gives the full 32-bit instruction word;
- everything else, breakpoints included, gives zero.

Software can write the cause and exception PC registers through a small write port. A write to the trap value register is quietly dropped and raises no fault.

Top module: `trap_select_capture`

## Requirements
- R1: The synchronous flag bits of `excFlags` are ordered by priority, and the lowest set bit wins. The bits map as follows: bit0 fetch misaligned (code 0), bit1 fetch access fault (1), bit2 illegal instruction (2), bit3 environment call from M-mode (11), bit4 environment call from U-mode (8), bit5 breakpoint (3), bit6 store misaligned (6), bit7 load misaligned (4), bit8 store access fault (7), bit9 load access fault (5). A synchronous cause word has bit 31 clear.
- R2: Any set bit of `excFlags` takes priority over every interrupt line.
- R3: An interrupt cause word has bit 31 set. Fast channel i (`fastIrq[i]`, 0 to 15) gives code 16+i, and a lower channel number wins.
- R4: With no fast channel pending, the external interrupt (code 11) beats the software interrupt (code 3), which beats the timer interrupt (code 7).
- R5: On a taken trap, `epcReg` receives `curPc` for a synchronous fault and `nextPc` for an interrupt.
- R6: For fetch misaligned and fetch access faults, `tvalReg` receives `curPc` with bit 0 forced to 0.
- R7: For load or store misaligned and access faults, `tvalReg` receives `dataAddr`.
- R8: For an illegal instruction, `tvalReg` receives `instWord`.
- R9: For breakpoints, both environment calls and all interrupts, `tvalReg` receives zero.
- R10: `trapTake` is high in exactly those cycles in which some request is pending, and `trapCause` carries the selected cause word. On that clock edge `causeReg` takes `trapCause`, and all three registers are written together.
- R11: With no request pending and no software write, none of the three registers changes.
- R12: Software writes use `wrEn` with `wrSel`: 0 selects the cause register and 1 selects the exception PC. With `wrSel` = 2 the trap value register is addressed, but the write is ignored. A trap taken in the same cycle overrides a software write.
- R13: After reset, all three registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| excFlags | input | 10 | Synchronous fault flags in priority order |
| fastIrq | input | 16 | Pre-masked fast interrupt channels |
| extIrq | input | 1 | Pre-masked machine external interrupt |
| swIrq | input | 1 | Pre-masked machine software interrupt |
| timerIrq | input | 1 | Pre-masked machine timer interrupt |
| curPc | input | 32 | PC of the instruction in execution |
| nextPc | input | 32 | Address of the next unexecuted instruction |
| dataAddr | input | 32 | Address of the faulting data access |
| instWord | input | 32 | Decoded (decompressed) instruction word |
| wrEn | input | 1 | Software register write strobe |
| wrSel | input | 2 | Software write target select |
| wrData | input | 32 | Software write data |
| trapTake | output | 1 | A trap is accepted this cycle |
| trapCause | output | 32 | Cause word of the selected request |
| causeReg | output | 32 | Trap cause register |
| epcReg | output | 32 | Exception PC register |
| tvalReg | output | 32 | Trap value register |

## Verification
The bench builds the block with its defaults: a 32-bit data path and sixteen fast channels. With these values the full 29-level order can be observed at the ports, including the highest fast channel (code 31) and its hand-over to the three standard interrupts. The odd `curPc` value makes the bit-0 clearing of fetch-fault trap values visible. The distinct data address and instruction word show which source fed the trap value.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int NUM_SYNC = 10;

  typedef enum logic [1:0] {
    TV_ZERO  = 2'd0,
    TV_FETCH = 2'd1,
    TV_DATA  = 2'd2,
    TV_INST  = 2'd3
  } tvalSrcE;

  typedef struct packed {
    logic    take;
    logic    useNext;
    tvalSrcE tvalSrc;
    logic    wrCause;
    logic    wrEpc;
  } ctrlStrobeS;

  localparam logic [1:0] SEL_CAUSE = 2'd0;
  localparam logic [1:0] SEL_EPC   = 2'd1;

  // flag index -> architectural cause code
  function automatic logic [4:0] syncCode(input int idx);
    case (idx)
      0: syncCode = 5'd0;
      1: syncCode = 5'd1;
      2: syncCode = 5'd2;
      3: syncCode = 5'd11;
      4: syncCode = 5'd8;
      5: syncCode = 5'd3;
      6: syncCode = 5'd6;
      7: syncCode = 5'd4;
      8: syncCode = 5'd7;
      default: syncCode = 5'd5;
    endcase
  endfunction

  function automatic tvalSrcE syncTval(input int idx);
    case (idx)
      0, 1:       syncTval = TV_FETCH;
      2:          syncTval = TV_INST;
      6, 7, 8, 9: syncTval = TV_DATA;
      default:    syncTval = TV_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_FAST = 16
) (
  input  logic [NUM_SYNC-1:0] excFlags,
  input  logic [NUM_FAST-1:0] fastIrq,
  input  logic                extIrq,
  input  logic                swIrq,
  input  logic                timerIrq,
  input  logic                wrEn,
  input  logic [1:0]          wrSel,
  output ctrlStrobeS          strobe,
  output logic [XLEN-1:0]     trapCause
);

  localparam int FAST_BASE = 16;
  localparam int NUM_IRQ   = NUM_FAST + 3;
  localparam int CODE_W    = $clog2(FAST_BASE + NUM_FAST);

  logic [NUM_IRQ-1:0] irqVec;
  logic [CODE_W-1:0]  irqCode [NUM_IRQ];

  assign irqVec = {timerIrq, swIrq, extIrq, fastIrq};

  // per-line interrupt code table
  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_code
    if (k < NUM_FAST) begin : g_fast
      assign irqCode[k] = CODE_W'(FAST_BASE + k);
    end else if (k == NUM_FAST) begin : g_ext
      assign irqCode[k] = CODE_W'(11);
    end else if (k == NUM_FAST + 1) begin : g_sw
      assign irqCode[k] = CODE_W'(3);
    end else begin : g_tmr
      assign irqCode[k] = CODE_W'(7);
    end
  end

  logic              syncHit;
  logic [4:0]        syncSel;
  tvalSrcE           syncTv;
  logic              irqHit;
  logic [CODE_W-1:0] irqSel;

  always_comb begin
    syncHit = 1'b0;
    syncSel = '0;
    syncTv  = TV_ZERO;
    for (int i = NUM_SYNC - 1; i >= 0; i--) begin
      if (excFlags[i]) begin
        syncHit = 1'b1;
        syncSel = syncCode(i);
        syncTv  = syncTval(i);
      end
    end
  end

  always_comb begin
    irqHit = 1'b0;
    irqSel = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (irqVec[i]) begin
        irqHit = 1'b1;
        irqSel = irqCode[i];
      end
    end
  end

  always_comb begin
    trapCause = '0;
    if (syncHit) begin
      trapCause[4:0] = syncSel;
    end else if (irqHit) begin
      trapCause[XLEN-1]   = 1'b1;
      trapCause[CODE_W-1:0] = irqSel;
    end
  end

  always_comb begin
    strobe.take    = syncHit | irqHit;
    strobe.useNext = ~syncHit & irqHit;
    strobe.tvalSrc = syncHit ? syncTv : TV_ZERO;
    strobe.wrCause = strobe.take | (wrEn & (wrSel == SEL_CAUSE));
    strobe.wrEpc   = strobe.take | (wrEn & (wrSel == SEL_EPC));
  end

endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobeS      strobe,
  input  logic [XLEN-1:0] trapCause,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] nextPc,
  input  logic [XLEN-1:0] dataAddr,
  input  logic [XLEN-1:0] instWord,
  input  logic [XLEN-1:0] wrData,
  output logic [XLEN-1:0] causeReg,
  output logic [XLEN-1:0] epcReg,
  output logic [XLEN-1:0] tvalReg
);

  logic [XLEN-1:0] tvalNext;
  logic [XLEN-1:0] fetchAddr;

  assign fetchAddr = {curPc[XLEN-1:1], 1'b0};

  always_comb begin
    case (strobe.tvalSrc)
      TV_FETCH: tvalNext = fetchAddr;
      TV_DATA:  tvalNext = dataAddr;
      TV_INST:  tvalNext = instWord;
      default:  tvalNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeReg <= '0;
      epcReg   <= '0;
      tvalReg  <= '0;
    end else begin
      if (strobe.wrCause) causeReg <= strobe.take ? trapCause : wrData;
      if (strobe.wrEpc)
        epcReg <= strobe.take ? (strobe.useNext ? nextPc : curPc) : wrData;
      if (strobe.take) tvalReg <= tvalNext;
    end
  end

endmodule

// File: rtl/trap_select_capture.sv
module trap_select_capture
  import trap_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_FAST = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SYNC-1:0] excFlags,
  input  logic [NUM_FAST-1:0] fastIrq,
  input  logic                extIrq,
  input  logic                swIrq,
  input  logic                timerIrq,
  input  logic [XLEN-1:0]     curPc,
  input  logic [XLEN-1:0]     nextPc,
  input  logic [XLEN-1:0]     dataAddr,
  input  logic [XLEN-1:0]     instWord,
  input  logic                wrEn,
  input  logic [1:0]          wrSel,
  input  logic [XLEN-1:0]     wrData,
  output logic                trapTake,
  output logic [XLEN-1:0]     trapCause,
  output logic [XLEN-1:0]     causeReg,
  output logic [XLEN-1:0]     epcReg,
  output logic [XLEN-1:0]     tvalReg
);

  ctrlStrobeS strobe;

  trap_ctrl #(.XLEN(XLEN), .NUM_FAST(NUM_FAST)) u_ctrl (
    .excFlags (excFlags),
    .fastIrq  (fastIrq),
    .extIrq   (extIrq),
    .swIrq    (swIrq),
    .timerIrq (timerIrq),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .strobe   (strobe),
    .trapCause(trapCause)
  );

  trap_dp #(.XLEN(XLEN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .trapCause(trapCause),
    .curPc    (curPc),
    .nextPc   (nextPc),
    .dataAddr (dataAddr),
    .instWord (instWord),
    .wrData   (wrData),
    .causeReg (causeReg),
    .epcReg   (epcReg),
    .tvalReg  (tvalReg)
  );

  assign trapTake = strobe.take;

endmodule

// File: rtl/trap_chk.sv
module trap_chk
  import trap_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_FAST = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_SYNC-1:0] excFlags,
  input logic [NUM_FAST-1:0] fastIrq,
  input logic                extIrq,
  input logic                swIrq,
  input logic                timerIrq,
  input logic [XLEN-1:0]     curPc,
  input logic [XLEN-1:0]     nextPc,
  input logic                wrEn,
  input logic                trapTake,
  input logic [XLEN-1:0]     trapCause,
  input logic [XLEN-1:0]     causeReg,
  input logic [XLEN-1:0]     epcReg,
  input logic [XLEN-1:0]     tvalReg
);

  // R2
  sync_over_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excFlags != '0) |-> !trapCause[XLEN-1]);

  // R3
  fast_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excFlags == '0 && fastIrq[0]) |-> trapCause == {1'b1, {(XLEN-6){1'b0}}, 5'd16});

  // R10
  take_when_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapTake == ((excFlags != '0) || (fastIrq != '0) || extIrq || swIrq || timerIrq));

  // R10
  cause_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapTake |=> causeReg == $past(trapCause));

  // R5
  epc_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapTake && excFlags != '0) |=> epcReg == $past(curPc));

  // R5
  epc_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapTake && excFlags == '0) |=> epcReg == $past(nextPc));

  // R9
  irq_tval_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapTake && trapCause[XLEN-1]) |=> tvalReg == '0);

  // R12
  tval_readonly_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trapTake |=> $stable(tvalReg));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!trapTake && !wrEn) |=> ($stable(causeReg) && $stable(epcReg)));

endmodule

bind trap_select_capture trap_chk #(.XLEN(XLEN), .NUM_FAST(NUM_FAST)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .excFlags (excFlags),
  .fastIrq  (fastIrq),
  .extIrq   (extIrq),
  .swIrq    (swIrq),
  .timerIrq (timerIrq),
  .curPc    (curPc),
  .nextPc   (nextPc),
  .wrEn     (wrEn),
  .trapTake (trapTake),
  .trapCause(trapCause),
  .causeReg (causeReg),
  .epcReg   (epcReg),
  .tvalReg  (tvalReg)
);

// File: tb/test_trap_select_capture.sv
module test_trap_select_capture;

  localparam logic [31:0] PC_CUR  = 32'h0000_1003;
  localparam logic [31:0] PC_NEXT = 32'h0000_2004;
  localparam logic [31:0] D_ADDR  = 32'hDEAD_BEE1;
  localparam logic [31:0] I_WORD  = 32'h1234_5678;
  localparam logic [31:0] FETCHV  = 32'h0000_1002;

  typedef struct packed {
    logic [9:0]  exc;
    logic [15:0] fast;
    logic [2:0]  stdIrq;   // {ext, sw, timer}
    logic [31:0] expCause;
    logic        expNext;
    logic [31:0] expTval;
  } vecT;

  localparam int NV = 17;
  localparam vecT VECS [NV] = '{
    '{10'h3FF, 16'h0000, 3'b000, 32'h0000_0000, 1'b0, FETCHV},  // R1 R6
    '{10'h3FE, 16'h0000, 3'b000, 32'h0000_0001, 1'b0, FETCHV},  // R1 R6
    '{10'h3FC, 16'h0000, 3'b000, 32'h0000_0002, 1'b0, I_WORD},  // R1 R8
    '{10'h3F8, 16'h0000, 3'b000, 32'h0000_000B, 1'b0, 32'h0},   // R1 R9
    '{10'h3F0, 16'h0000, 3'b000, 32'h0000_0008, 1'b0, 32'h0},   // R1 R9
    '{10'h3E0, 16'h0000, 3'b000, 32'h0000_0003, 1'b0, 32'h0},   // R1 R9
    '{10'h3C0, 16'h0000, 3'b000, 32'h0000_0006, 1'b0, D_ADDR},  // R1 R7
    '{10'h380, 16'h0000, 3'b000, 32'h0000_0004, 1'b0, D_ADDR},  // R1 R7
    '{10'h300, 16'h0000, 3'b000, 32'h0000_0007, 1'b0, D_ADDR},  // R1 R7
    '{10'h200, 16'h0000, 3'b000, 32'h0000_0005, 1'b0, D_ADDR},  // R1 R7
    '{10'h200, 16'hFFFF, 3'b111, 32'h0000_0005, 1'b0, D_ADDR},  // R2
    '{10'h000, 16'hFFFF, 3'b111, 32'h8000_0010, 1'b1, 32'h0},   // R3 R5 R9
    '{10'h000, 16'h8000, 3'b100, 32'h8000_001F, 1'b1, 32'h0},   // R3
    '{10'h000, 16'h0120, 3'b011, 32'h8000_0015, 1'b1, 32'h0},   // R3
    '{10'h000, 16'h0000, 3'b111, 32'h8000_000B, 1'b1, 32'h0},   // R4
    '{10'h000, 16'h0000, 3'b011, 32'h8000_0003, 1'b1, 32'h0},   // R4
    '{10'h000, 16'h0000, 3'b001, 32'h8000_0007, 1'b1, 32'h0}    // R4
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  excFlags = '0;
  logic [15:0] fastIrq = '0;
  logic        extIrq = 1'b0, swIrq = 1'b0, timerIrq = 1'b0;
  logic [31:0] curPc = PC_CUR, nextPc = PC_NEXT, dataAddr = D_ADDR, instWord = I_WORD;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic        trapTake;
  logic [31:0] trapCause, causeReg, epcReg, tvalReg;

  int testCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;

  trap_select_capture i_trap_select_capture (
    .clk(clk), .rstN(rstN), .excFlags(excFlags), .fastIrq(fastIrq),
    .extIrq(extIrq), .swIrq(swIrq), .timerIrq(timerIrq),
    .curPc(curPc), .nextPc(nextPc), .dataAddr(dataAddr), .instWord(instWord),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .trapTake(trapTake), .trapCause(trapCause),
    .causeReg(causeReg), .epcReg(epcReg), .tvalReg(tvalReg)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    excFlags = '0; fastIrq = '0; extIrq = 1'b0; swIrq = 1'b0; timerIrq = 1'b0;
    wrEn = 1'b0; wrSel = '0; wrData = '0;
  endtask

  initial begin
    #1_000_000;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] holdCause, holdEpc, holdTval;
    repeat (3) @(posedge clk);
    #2;
    check("R13", "causeReg reset", causeReg, 32'h0);
    check("R13", "epcReg reset", epcReg, 32'h0);
    check("R13", "tvalReg reset", tvalReg, 32'h0);
    check("R10", "trapTake idle", {31'b0, trapTake}, 32'h0);
    @(negedge clk) rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      excFlags = VECS[v].exc;
      fastIrq  = VECS[v].fast;
      {extIrq, swIrq, timerIrq} = VECS[v].stdIrq;
      #2;
      check("R10", "trapTake", {31'b0, trapTake}, 32'h1);
      check("R1-R4 table", "trapCause", trapCause, VECS[v].expCause);
      @(posedge clk);
      #1;
      check("R10", "causeReg", causeReg, VECS[v].expCause);
      check("R5", "epcReg", epcReg, VECS[v].expNext ? PC_NEXT : PC_CUR);
      check("R6-R9 table", "tvalReg", tvalReg, VECS[v].expTval);
      @(negedge clk) clearIn();
    end

    // R11: idle cycles leave all registers unchanged
    holdCause = causeReg; holdEpc = epcReg; holdTval = tvalReg;
    repeat (3) @(posedge clk);
    #1;
    check("R11", "causeReg hold", causeReg, holdCause);
    check("R11", "epcReg hold", epcReg, holdEpc);
    check("R11", "tvalReg hold", tvalReg, holdTval);
    check("R10", "trapTake low", {31'b0, trapTake}, 32'h0);

    // R12: software writes
    @(negedge clk); wrEn = 1'b1; wrSel = 2'd0; wrData = 32'h0000_ABCD;
    @(negedge clk); wrSel = 2'd1; wrData = 32'h0000_4000;
    @(negedge clk); wrSel = 2'd2; wrData = 32'h5555_5555;
    @(negedge clk); clearIn();
    check("R12", "cause write", causeReg, 32'h0000_ABCD);
    check("R12", "epc write", epcReg, 32'h0000_4000);
    check("R12", "tval write ignored", tvalReg, holdTval);
    check("R12", "no trap on tval write", {31'b0, trapTake}, 32'h0);

    // R12: trap beats software write in the same cycle
    @(negedge clk);
    excFlags = 10'h004; wrEn = 1'b1; wrSel = 2'd0; wrData = 32'h0000_0077;
    @(posedge clk);
    #1;
    check("R12", "trap over write cause", causeReg, 32'h0000_0002);
    check("R8", "illegal tval", tvalReg, I_WORD);
    @(negedge clk) clearIn();

    // R6: fetch fault with a different odd PC
    @(negedge clk); curPc = 32'hFFFF_FFFF; excFlags = 10'h002;
    @(posedge clk);
    #1;
    check("R6", "fetch tval bit0 clear", tvalReg, 32'hFFFF_FFFE);
    check("R5", "sync epc", epcReg, 32'hFFFF_FFFF);
    @(negedge clk) begin clearIn(); curPc = PC_CUR; end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule